// File: doc/BRIEF.md
# Decode-Stage Micro-op Fusion Classifier and Cache Line Packer

This block sits at the end of an instruction decoder. It takes one pre-decoded instruction descriptor per handshake: the memory addressing class, the size and value of the displacement, the size and value of the immediate, a flag for an 8-bit control immediate, and a per-opcode flag that forbids fusion. From these fields it decides whether the load part and the operation part of a memory instruction leave the decoder as one fused micro-op or as two separate micro-ops.

It also works out how many micro-op cache entries the instruction needs. The entry count depends on the micro-op count and on how many bits of constant data the instruction carries. A 32-bit constant whose value fits a signed 16-bit integer is stored in compressed form.

The instructions are then packed in order into cache lines of fixed capacity. An instruction never straddles two lines. When the entries of the next instruction do not fit in the space left on the current line, that instruction opens a new line. Each accepted instruction produces one output record holding its micro-op count, its entry count and the index of the line it was placed on. The record appears one cycle after the instruction is accepted and stays stable while the consumer stalls.

Top module: `mf_fuse_alloc`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1. The first instruction accepted after reset is placed on line 0.
- R2: A memory instruction with a base-only (in_amode=1) or indexed (in_amode=2) operand, no control immediate and no no-fuse flag, fuses into one micro-op (out_uops=1). This holds whatever its immediate or displacement is.
- R3: A rip-relative memory operand (in_amode=3) that comes with an immediate (in_imm_sz≠0) gives two micro-ops. The same operand without an immediate gives one micro-op.
- R4: A memory instruction with in_ctl_imm8=1 gives two micro-ops.
- R5: A memory instruction with in_no_fuse=1 gives two micro-ops.
- R6: An instruction without a memory operand (in_amode=0) gives one micro-op. in_ctl_imm8, in_no_fuse and the displacement fields have no effect on it.
- R7: out_entries = out_uops + 1 when the constant data is wider than 32 bits, and out_entries = out_uops otherwise. The constant data is counted as follows:
  - displacement: counted only for memory instructions; in_disp_sz 0 = none, 1 = 8 bits, 2 or 3 = 32 bits.
  - immediate: in_imm_sz 0 = none, 1 = 8, 2 = 16, 3 = 32 bits.
  - any 32-bit field whose value is a sign-extended 16-bit number counts as 16 bits.
- R8: Let fill be the number of entries already used on the current line. If fill + out_entries exceeds LINE_ENTRIES (6), the instruction goes on the next line index and that line's fill becomes out_entries. Otherwise the instruction stays on the current line. The line index wraps modulo 2^LINE_IDX_W.
- R9: An instruction accepted at a clock edge appears on the output (out_valid=1) right after that edge. With out_ready=1 and no new input, out_valid returns to 0 one cycle later.
- R10: While out_valid=1 and out_ready=0, in_ready is 0 and the output record stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Descriptor can be accepted |
| in_amode | input | 2 | 0 none, 1 base, 2 indexed, 3 rip-relative |
| in_disp_sz | input | 2 | Displacement size code |
| in_disp | input | 32 | Displacement value |
| in_imm_sz | input | 2 | Immediate size code |
| in_imm | input | 32 | Immediate value |
| in_ctl_imm8 | input | 1 | Instruction has an 8-bit control immediate |
| in_no_fuse | input | 1 | Opcode class never fuses |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Consumer takes the record |
| out_uops | output | 2 | Micro-op count (1 or 2) |
| out_entries | output | 2 | Cache entries used (1 to 3) |
| out_line | output | LINE_IDX_W | Line index of the instruction |

## Verification
The bench drives a rip-relative operand with a tiny immediate. A design that judged fusion by data size alone would report one micro-op for it. It also drives indexed operands with no blocking flag, where a design that treats index registers as a fusion blocker would report two.

For entry costs, the bench pairs 32-bit fields that do and do not compress to 16 bits, including the value -32768. A wrong sign-extension test would move the count by one entry. Streams of instructions land exactly on the six-entry boundary and run long enough for the line index to wrap. An off-by-one in the fit test would split lines early or overfill them.

Random stalls on out_ready expose a record that changes, or an input that is taken, while the output is held.

// File: rtl/mf_pkg.sv
package mf_pkg;

  typedef enum logic [1:0] {
    AM_NONE  = 2'd0,
    AM_BASE  = 2'd1,
    AM_INDEX = 2'd2,
    AM_RIP   = 2'd3
  } amode_e;

  localparam logic [1:0] DSZ_NONE = 2'd0;
  localparam logic [1:0] DSZ_8    = 2'd1;

  localparam logic [1:0] ISZ_NONE = 2'd0;
  localparam logic [1:0] ISZ_8    = 2'd1;
  localparam logic [1:0] ISZ_16   = 2'd2;

  // True when a 32-bit value is a sign-extended 16-bit number
  function automatic logic fits_s16(input logic [31:0] v);
    return (v[31:15] == 17'h00000) || (v[31:15] == 17'h1FFFF);
  endfunction

endpackage

// File: rtl/mf_fuse_classify.sv
module mf_fuse_classify
  import mf_pkg::*;
(
  input  amode_e     amode,
  input  logic [1:0] imm_sz,
  input  logic       ctl_imm8,
  input  logic       no_fuse,
  output logic       has_mem,
  output logic [1:0] uops
);

  logic rip_imm;
  logic blocked;

  always_comb begin
    has_mem = (amode != AM_NONE);
    rip_imm = (amode == AM_RIP) && (imm_sz != ISZ_NONE);
    blocked = has_mem && (rip_imm || ctl_imm8 || no_fuse);
    uops    = blocked ? 2'd2 : 2'd1;
  end

  always_comb begin
    a_r6_no_mem_single: assert (has_mem || uops == 2'd1);
  end

endmodule

// File: rtl/mf_const_cost.sv
module mf_const_cost
  import mf_pkg::*;
#(
  parameter int BUDGET_W = 32,
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  localparam int BITS_W  = $clog2(2 * WIDE_W + 1)
) (
  input  logic        has_mem,
  input  logic [1:0]  disp_sz,
  input  logic [31:0] disp,
  input  logic [1:0]  imm_sz,
  input  logic [31:0] imm,
  output logic        wide
);

  localparam int NFIELD = 2;

  logic [BITS_W-1:0] fbits [NFIELD];
  logic [BITS_W-1:0] total;

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    if (g == 0) begin : g_disp
      always_comb begin
        if (!has_mem || disp_sz == DSZ_NONE) fbits[g] = '0;
        else if (disp_sz == DSZ_8)           fbits[g] = BITS_W'(8);
        else if (fits_s16(disp))             fbits[g] = BITS_W'(NARROW_W);
        else                                 fbits[g] = BITS_W'(WIDE_W);
      end
    end else begin : g_imm
      always_comb begin
        if (imm_sz == ISZ_NONE)      fbits[g] = '0;
        else if (imm_sz == ISZ_8)    fbits[g] = BITS_W'(8);
        else if (imm_sz == ISZ_16)   fbits[g] = BITS_W'(NARROW_W);
        else if (fits_s16(imm))      fbits[g] = BITS_W'(NARROW_W);
        else                         fbits[g] = BITS_W'(WIDE_W);
      end
    end
  end

  always_comb begin
    total = '0;
    for (int i = 0; i < NFIELD; i++) total = total + fbits[i];
    wide = (total > BITS_W'(BUDGET_W));
  end

  always_comb begin
    a_r7_total_bound: assert (total <= BITS_W'(2 * WIDE_W));
  end

endmodule

// File: rtl/mf_line_alloc.sv
module mf_line_alloc #(
  parameter int LINE_ENTRIES = 6,
  parameter int LINE_IDX_W   = 8,
  parameter int ENT_W        = 2,
  localparam int FILL_W      = $clog2(LINE_ENTRIES + 1),
  localparam int SUM_W       = FILL_W + ENT_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  take,
  input  logic [ENT_W-1:0]      entries,
  output logic [LINE_IDX_W-1:0] line_for_in
);

  logic [FILL_W-1:0]     fill_q;
  logic [LINE_IDX_W-1:0] line_q;
  logic [SUM_W-1:0]      sum;
  logic                  new_line;

  always_comb begin
    sum         = SUM_W'(fill_q) + SUM_W'(entries);
    new_line    = (sum > SUM_W'(LINE_ENTRIES));
    line_for_in = new_line ? line_q + 1'b1 : line_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= '0;
      line_q <= '0;
    end else if (take) begin
      line_q <= line_for_in;
      fill_q <= new_line ? FILL_W'(entries) : FILL_W'(sum);
    end
  end

  initial begin
    a_r8_cap_holds_max: assert (LINE_ENTRIES >= 3);
  end

  a_r8_fill_bound: assert property (@(posedge clk) disable iff (rst)
    fill_q <= FILL_W'(LINE_ENTRIES));

  a_r8_line_step: assert property (@(posedge clk) disable iff (rst)
    take |=> (line_q == $past(line_q)) || (line_q == $past(line_q) + 1'b1));

  a_r8_no_split: assert property (@(posedge clk) disable iff (rst)
    take |=> SUM_W'(fill_q) >= SUM_W'($past(entries)));

endmodule

// File: rtl/mf_fuse_alloc.sv
module mf_fuse_alloc
  import mf_pkg::*;
#(
  parameter int LINE_ENTRIES = 6,
  parameter int LINE_IDX_W   = 8,
  parameter int BUDGET_W     = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [1:0]            in_amode,
  input  logic [1:0]            in_disp_sz,
  input  logic [31:0]           in_disp,
  input  logic [1:0]            in_imm_sz,
  input  logic [31:0]           in_imm,
  input  logic                  in_ctl_imm8,
  input  logic                  in_no_fuse,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [1:0]            out_uops,
  output logic [1:0]            out_entries,
  output logic [LINE_IDX_W-1:0] out_line
);

  localparam int ENT_W = 2;

  amode_e                amode;
  logic                  has_mem;
  logic [1:0]            uops;
  logic                  wide;
  logic [ENT_W-1:0]      entries;
  logic [LINE_IDX_W-1:0] line_for_in;
  logic                  take;

  logic                  vld_q;
  logic [1:0]            uops_q;
  logic [ENT_W-1:0]      ent_q;
  logic [LINE_IDX_W-1:0] line_q;

  assign amode = amode_e'(in_amode);

  mf_fuse_classify i_classify (
    .amode    (amode),
    .imm_sz   (in_imm_sz),
    .ctl_imm8 (in_ctl_imm8),
    .no_fuse  (in_no_fuse),
    .has_mem  (has_mem),
    .uops     (uops)
  );

  mf_const_cost #(.BUDGET_W(BUDGET_W)) i_cost (
    .has_mem (has_mem),
    .disp_sz (in_disp_sz),
    .disp    (in_disp),
    .imm_sz  (in_imm_sz),
    .imm     (in_imm),
    .wide    (wide)
  );

  assign entries = uops + ENT_W'(wide);

  mf_line_alloc #(
    .LINE_ENTRIES (LINE_ENTRIES),
    .LINE_IDX_W   (LINE_IDX_W),
    .ENT_W        (ENT_W)
  ) i_alloc (
    .clk         (clk),
    .rst         (rst),
    .take        (take),
    .entries     (entries),
    .line_for_in (line_for_in)
  );

  assign in_ready = !vld_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      uops_q <= '0;
      ent_q  <= '0;
      line_q <= '0;
    end else if (take) begin
      vld_q  <= 1'b1;
      uops_q <= uops;
      ent_q  <= entries;
      line_q <= line_for_in;
    end else if (out_ready) begin
      vld_q  <= 1'b0;
    end
  end

  assign out_valid   = vld_q;
  assign out_uops    = uops_q;
  assign out_entries = ent_q;
  assign out_line    = line_q;

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_uops)
      && $stable(out_entries) && $stable(out_line));

  a_r9_accept_shows: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  a_r3_rip_imm_split: assert property (@(posedge clk) disable iff (rst)
    (take && in_amode == 2'd3 && in_imm_sz != 2'd0) |=> out_uops == 2'd2);

  a_r4_ctl_split: assert property (@(posedge clk) disable iff (rst)
    (take && in_amode != 2'd0 && in_ctl_imm8) |=> out_uops == 2'd2);

  a_r5_nofuse_split: assert property (@(posedge clk) disable iff (rst)
    (take && in_amode != 2'd0 && in_no_fuse) |=> out_uops == 2'd2);

  a_r6_no_mem_one: assert property (@(posedge clk) disable iff (rst)
    (take && in_amode == 2'd0) |=> out_uops == 2'd1);

  a_r7_entry_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_entries >= out_uops) && (out_entries <= out_uops + 2'd1)
      && (out_uops != 2'd0));

endmodule

// File: tb/test_mf_fuse_alloc.sv
module test_mf_fuse_alloc;

  localparam int CAP = 6;
  localparam int LW  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_ready;
  logic [1:0] in_amode = '0, in_disp_sz = '0, in_imm_sz = '0;
  logic [31:0] in_disp = '0, in_imm = '0;
  logic in_ctl_imm8 = 1'b0, in_no_fuse = 1'b0;
  logic out_valid, out_ready = 1'b1;
  logic [1:0] out_uops, out_entries;
  logic [LW-1:0] out_line;

  always #2.5 clk = ~clk;

  mf_fuse_alloc #(.LINE_ENTRIES(CAP), .LINE_IDX_W(LW)) i_mf_fuse_alloc (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_amode(in_amode), .in_disp_sz(in_disp_sz), .in_disp(in_disp),
    .in_imm_sz(in_imm_sz), .in_imm(in_imm), .in_ctl_imm8(in_ctl_imm8),
    .in_no_fuse(in_no_fuse), .out_valid(out_valid), .out_ready(out_ready),
    .out_uops(out_uops), .out_entries(out_entries), .out_line(out_line)
  );

  int n_chk = 0, n_bad = 0;
  int q_u[$], q_e[$], q_l[$];
  string q_t[$];
  int m_fill = 0, m_line = 0;
  bit prev_hold = 0;
  int prev_u, prev_e, prev_l;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit fit16(logic [31:0] v);
    return (v[31:15] == 17'h0) || (v[31:15] == 17'h1FFFF);
  endfunction

  function automatic int m_uops(int am, int isz, bit ctl, bit nf);
    if (am == 0) return 1;
    if (am == 3 && isz != 0) return 2;
    if (ctl || nf) return 2;
    return 1;
  endfunction

  function automatic int m_entries(int u, int am, int dsz, logic [31:0] d,
                                   int isz, logic [31:0] im);
    int b = 0;
    if (am != 0) begin
      if (dsz == 1) b += 8;
      else if (dsz >= 2) b += fit16(d) ? 16 : 32;
    end
    if (isz == 1) b += 8;
    else if (isz == 2) b += 16;
    else if (isz == 3) b += fit16(im) ? 16 : 32;
    return u + ((b > 32) ? 1 : 0);
  endfunction

  // One cycle, entered and left at a falling edge
  task automatic step(bit iv, int am, int dsz, logic [31:0] d, int isz,
                      logic [31:0] im, bit ctl, bit nf, bit rdy,
                      int eu, int ee, string tag);
    if (prev_hold) begin
      check("R10 hold uops", out_uops, prev_u);
      check("R10 hold entries", out_entries, prev_e);
      check("R10 hold line", out_line, prev_l);
      check("R10 still valid", out_valid, 1);
    end
    in_valid = iv; in_amode = 2'(am); in_disp_sz = 2'(dsz); in_disp = d;
    in_imm_sz = 2'(isz); in_imm = im; in_ctl_imm8 = ctl; in_no_fuse = nf;
    out_ready = rdy;
    #1;
    prev_hold = 0;
    if (out_valid && out_ready) begin
      if (q_u.size() == 0) check("R9 unexpected record", 1, 0);
      else begin
        string t;
        t = q_t.pop_front();
        check({t, " uops"}, out_uops, q_u.pop_front());
        check({t, " entries"}, out_entries, q_e.pop_front());
        check({"R8 line ", t}, out_line, q_l.pop_front());
      end
    end else if (out_valid) begin
      check("R10 in_ready low", in_ready, 0);
      prev_hold = 1; prev_u = out_uops; prev_e = out_entries; prev_l = out_line;
    end
    if (iv && in_ready) begin
      if (m_fill + ee > CAP) begin
        m_line = (m_line + 1) % (1 << LW);
        m_fill = ee;
      end else m_fill += ee;
      q_u.push_back(eu); q_e.push_back(ee); q_l.push_back(m_line);
      q_t.push_back(tag);
    end
    @(negedge clk);
  endtask

  task automatic send(int am, int dsz, logic [31:0] d, int isz, logic [31:0] im,
                      bit ctl, bit nf, int eu, int ee, string tag);
    step(1, am, dsz, d, isz, im, ctl, nf, 1, eu, ee, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset out_valid", out_valid, 0);
    check("R1 reset in_ready", in_ready, 1);

    // Directed: line 0 fills to exactly 6 entries, then a new line opens
    send(1, 1, 32'h10, 0, 0, 0, 0, 1, 1, "R2 base disp8");
    send(2, 2, 32'h12345, 3, 32'h7FFF, 0, 0, 1, 2, "R7 indexed wide data");
    send(2, 2, 32'h100, 3, 32'hFFFF8000, 0, 0, 1, 1, "R7 compressed pair");
    send(3, 2, 32'h40, 1, 32'h1, 0, 0, 2, 2, "R3 rip with imm");
    send(3, 2, 32'h400000, 0, 0, 0, 0, 1, 1, "R3 rip no imm");
    send(1, 0, 0, 1, 32'h3, 1, 0, 2, 2, "R4 ctl imm8");
    send(2, 1, 32'h8, 0, 0, 0, 1, 2, 2, "R5 no-fuse class");
    send(0, 2, 32'h12345678, 3, 32'h12345678, 1, 1, 1, 1, "R6 no memory");
    send(2, 2, 32'h12345678, 3, 32'h80000000, 0, 0, 1, 2, "R7 both wide");
    send(3, 2, 32'h12345678, 2, 32'h1234, 0, 0, 2, 3, "R7 rip split wide");
    // R9: idle cycle drains the last record, then out_valid drops
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "idle");
    check("R9 valid drops", out_valid, 0);

    // Random traffic with stalls
    for (int i = 0; i < 6000; i++) begin
      int am, dsz, isz, u, e;
      logic [31:0] d, im;
      bit ctl, nf, iv, rdy;
      am  = $urandom % 4;
      dsz = $urandom % 4;
      isz = $urandom % 4;
      d   = ($urandom % 2) ? 32'($urandom % 65536) - 32'd32768 : $urandom;
      im  = ($urandom % 2) ? 32'($urandom % 65536) - 32'd32768 : $urandom;
      ctl = ($urandom % 6) == 0;
      nf  = ($urandom % 6) == 0;
      iv  = ($urandom % 4) != 0;
      rdy = ($urandom % 4) != 0;
      u = m_uops(am, isz, ctl, nf);
      e = m_entries(u, am, dsz, d, isz, im);
      step(iv, am, dsz, d, isz, im, ctl, nf, rdy, u, e, "R2-mix random");
    end
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "drain");
    check("R9 queue drained", q_u.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule